// File: doc/BRIEF.md
# Monochrome bitmap text-row fetcher

This block feeds a two-colour, high-resolution bitmap screen from video RAM. A timing generator elsewhere strobes it once per active pixel and pulses it once at the top of each frame. The block keeps its own column, line and row counters. It issues one RAM read for every eight active pixels and shifts each returned byte out as eight neighbouring pixels. Each output pixel is a single select bit: foreground or background.

Text lives in memory as seven character rows, each seven lines tall, sixteen bytes per line, with no padding between rows. On screen, two blank spacer lines follow each of the first six rows. The block creates those lines itself. During a spacer line it makes no read, leaves its line base unchanged and drives background. Sync generation and colour encoding are handled elsewhere.

Top module: `mono_text_fetch`

## Requirements
- R1: After reset `pix_valid`, `pix_fg` and `ram_rd` are 0. Until the first `frame_start`, active pixels come out as valid background (`pix_fg`=0) and start no read.
- R2: Each cycle with `pix_act`=1 and `frame_start`=0 yields exactly one cycle of `pix_valid`=1, three clock edges later. `pix_valid` is 0 in every other cycle.
- R3: A read is requested only on an active pixel whose column within the line is a multiple of 8. `ram_rd`=1 and `ram_addr` = line base + column/8 appear in the cycle after that pixel.
- R4: Pixels leave most significant bit first. Column c shows bit (7 - c mod 8) of the byte read for that group. A 1 is foreground (`pix_fg`=1) and a 0 is background.
- R5: `frame_start` reloads the line base to 0x0C2F. The first read after it uses that address. A second `frame_start` in mid-frame restarts from that address.
- R6: After each stored line of 128 active pixels, the line base advances by 16. Stored lines are therefore contiguous in RAM across row boundaries.
- R7: After each of the first six 7-line character rows, the next two lines are spacer lines. They read nothing, leave the line base unchanged and output background.
- R8: Once all 49 stored lines have been shown, further active pixels output background and start no read until the next `frame_start`.
- R9: Cycles with `pix_act`=0 advance no counter. Idle cycles inside a line or between lines do not change which pixel comes next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Top-of-frame pulse. Takes precedence over `pix_act` in the same cycle |
| pix_act | input | 1 | Active-pixel strobe, 128 per displayed line |
| ram_rd | output | 1 | Read request for `ram_addr` |
| ram_addr | output | 16 | Video RAM byte address |
| ram_data | input | 8 | Byte returned one clock edge after the request |
| pix_valid | output | 1 | `pix_fg` carries a pixel this cycle |
| pix_fg | output | 1 | 1 selects foreground, 0 selects background |

## Verification
Each RAM byte is derived from its address, so a wrong address, a wrong bit order or a wrong line base shows up as a wrong pixel. The first frame is run with continuous lines and a few idle cycles at each line end. The second frame is run with idle cycles inside every byte group and no gap between lines. This separates counting on active pixels from counting on clocks. Frames extend past 49 stored lines to expose any read or drawing after the end. Pixels before the first frame, and a restart in mid-frame, test the reload apart from the advance.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
    localparam int PIX_PER_BYTE = 8;

    typedef struct packed {
        logic valid;
        logic load;
        logic blank;
    } pix_ctl_t;
endpackage

// File: rtl/mbf_scan.sv
module mbf_scan
    import mbf_pkg::*;
#(
    parameter int          WIDTH   = 128,
    parameter int          GLYPH_H = 7,
    parameter int          ROWS    = 7,
    parameter int          GAP     = 2,
    parameter int          ADDR_W  = 16,
    parameter logic [15:0] START   = 16'h0C2F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              pix_act,
    output logic              ram_rd,
    output logic [ADDR_W-1:0] ram_addr,
    output pix_ctl_t          ctl
);
    localparam int BPL      = WIDTH / PIX_PER_BYTE;
    localparam int COL_W    = $clog2(WIDTH);
    localparam int SUB_MAX  = (GLYPH_H > GAP) ? GLYPH_H : GAP;
    localparam int SUB_W    = $clog2(SUB_MAX + 1);
    localparam int ROW_W    = $clog2(ROWS + 1);
    localparam int GAP_LAST = (GAP > 0) ? GAP - 1 : 0;

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [SUB_W-1:0]  sub;
        logic [ROW_W-1:0]  row;
        logic              gap;
        logic              done;
        logic [ADDR_W-1:0] base;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        pix_ctl_t          ctl;
    } scan_t;

    scan_t st_d, st_q;
    logic  blank_c, grp_c;

    always_comb begin
        st_d    = st_q;
        st_d.rd = 1'b0;
        st_d.ctl = '0;
        blank_c = st_q.gap | st_q.done;
        grp_c   = (st_q.col[2:0] == 3'd0);
        if (frame_start) begin
            st_d.col  = '0;
            st_d.sub  = '0;
            st_d.row  = '0;
            st_d.gap  = 1'b0;
            st_d.done = 1'b0;
            st_d.base = START[ADDR_W-1:0];
        end else if (pix_act) begin
            st_d.ctl.valid = 1'b1;
            st_d.ctl.blank = blank_c;
            st_d.ctl.load  = grp_c & ~blank_c;
            if (grp_c && !blank_c) begin
                st_d.rd   = 1'b1;
                st_d.addr = st_q.base + ADDR_W'(st_q.col >> 3);
            end
            if (st_q.col == COL_W'(WIDTH - 1)) begin
                st_d.col = '0;
                if (st_q.done) begin
                    st_d.done = 1'b1;
                end else if (st_q.gap) begin
                    if (st_q.sub == SUB_W'(GAP_LAST)) begin
                        st_d.sub = '0;
                        st_d.gap = 1'b0;
                    end else begin
                        st_d.sub = st_q.sub + 1'b1;
                    end
                end else begin
                    st_d.base = st_q.base + ADDR_W'(BPL);
                    if (st_q.sub == SUB_W'(GLYPH_H - 1)) begin
                        st_d.sub = '0;
                        if (st_q.row == ROW_W'(ROWS - 1)) begin
                            st_d.done = 1'b1;
                        end else begin
                            st_d.row = st_q.row + 1'b1;
                            st_d.gap = (GAP != 0);
                        end
                    end else begin
                        st_d.sub = st_q.sub + 1'b1;
                    end
                end
            end else begin
                st_d.col = st_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.done <= 1'b1;
            st_q.base <= START[ADDR_W-1:0];
            st_q.addr <= START[ADDR_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_rd   = st_q.rd;
    assign ram_addr = st_q.addr;
    assign ctl      = st_q.ctl;
endmodule

// File: rtl/mbf_delay.sv
module mbf_delay
    import mbf_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pix_ctl_t din,
    output pix_ctl_t dout
);
    generate
        if (STAGES == 0) begin : g_pass
            assign dout = din;
        end else begin : g_pipe
            pix_ctl_t pipe_d [STAGES];
            pix_ctl_t pipe_q [STAGES];

            always_comb begin
                pipe_d[0] = din;
                for (int i = 1; i < STAGES; i++) begin
                    pipe_d[i] = pipe_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                for (int i = 0; i < STAGES; i++) begin
                    if (!rst_n) pipe_q[i] <= '0;
                    else        pipe_q[i] <= pipe_d[i];
                end
            end

            assign dout = pipe_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mbf_shift.sv
module mbf_shift
    import mbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pix_ctl_t   ctl,
    input  logic [7:0] ram_data,
    output logic       pix_valid,
    output logic       pix_fg
);
    typedef struct packed {
        logic [7:0] sh;
        logic       vld;
        logic       fg;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d     = sh_q;
        sh_d.vld = ctl.valid;
        sh_d.fg  = 1'b0;
        if (ctl.valid && !ctl.blank) begin
            if (ctl.load) begin
                sh_d.fg = ram_data[7];
                sh_d.sh = {ram_data[6:0], 1'b0};
            end else begin
                sh_d.fg = sh_q.sh[7];
                sh_d.sh = {sh_q.sh[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign pix_valid = sh_q.vld;
    assign pix_fg    = sh_q.fg;
endmodule

// File: rtl/mono_text_fetch.sv
module mono_text_fetch
    import mbf_pkg::*;
#(
    parameter int          WIDTH   = 128,
    parameter int          GLYPH_H = 7,
    parameter int          ROWS    = 7,
    parameter int          GAP     = 2,
    parameter int          ADDR_W  = 16,
    parameter int          RAM_LAT = 1,
    parameter logic [15:0] START   = 16'h0C2F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              pix_act,
    output logic              ram_rd,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [7:0]        ram_data,
    output logic              pix_valid,
    output logic              pix_fg
);
    pix_ctl_t ctl_fetch, ctl_data;

    mbf_scan #(
        .WIDTH(WIDTH), .GLYPH_H(GLYPH_H), .ROWS(ROWS), .GAP(GAP),
        .ADDR_W(ADDR_W), .START(START)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_act(pix_act),
        .ram_rd(ram_rd), .ram_addr(ram_addr), .ctl(ctl_fetch)
    );

    mbf_delay #(.STAGES(RAM_LAT)) u_delay (
        .clk(clk), .rst_n(rst_n), .din(ctl_fetch), .dout(ctl_data)
    );

    mbf_shift u_shift (
        .clk(clk), .rst_n(rst_n), .ctl(ctl_data), .ram_data(ram_data),
        .pix_valid(pix_valid), .pix_fg(pix_fg)
    );
endmodule

// File: rtl/mbf_chk.sv
module mbf_chk #(
    parameter int          ADDR_W = 16,
    parameter int          LAT    = 3,
    parameter logic [15:0] START  = 16'h0C2F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              pix_act,
    input logic              ram_rd,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              pix_valid,
    input logic              pix_fg
);
    logic [LAT-1:0] act_hist;
    logic           first_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hist   <= '0;
            first_pend <= 1'b0;
        end else begin
            act_hist   <= {act_hist[LAT-2:0], pix_act & ~frame_start};
            first_pend <= frame_start ? 1'b1 : (ram_rd ? 1'b0 : first_pend);
        end
    end

    // R2
    pix_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid == act_hist[LAT-1]);

    // R3
    read_needs_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> $past(pix_act));

    // R4
    fg_only_when_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_fg |-> pix_valid);

    // R5
    first_read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd && first_pend) |-> ram_addr == START[ADDR_W-1:0]);
endmodule

bind mono_text_fetch mbf_chk #(.ADDR_W(ADDR_W), .LAT(RAM_LAT + 2), .START(START)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_act(pix_act),
    .ram_rd(ram_rd), .ram_addr(ram_addr), .pix_valid(pix_valid), .pix_fg(pix_fg)
);

// File: tb/tb_mono_text_fetch.sv
module tb_mono_text_fetch;
    localparam int CLK_P = 10;
    localparam int START = 16'h0C2F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        pix_act = 1'b0;
    logic        ram_rd;
    logic [15:0] ram_addr;
    logic [7:0]  ram_data = 8'h00;
    logic        pix_valid, pix_fg;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model state
    int    bm_line = -1;
    int    bm_col  = 0;
    int    idle_mod = 0;
    logic  ev [3] = '{0, 0, 0};
    logic  ef [3] = '{0, 0, 0};
    string et [3] = '{"R1", "R1", "R1"};
    logic  erd = 1'b0;
    logic [15:0] eaddr = '0;
    string rtag = "R1";

    always #(CLK_P/2) clk = ~clk;

    mono_text_fetch dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_act(pix_act),
        .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_data(ram_data),
        .pix_valid(pix_valid), .pix_fg(pix_fg)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        return 8'(a * 16'd13) ^ 8'(a >> 4) ^ 8'hA5;
    endfunction

    always @(posedge clk) ram_data <= memf(ram_addr);

    task automatic step(input logic act, input logic fs);
        int row, w, s;
        logic blank;
        @(negedge clk);
        n_cmp++;
        if ({pix_valid, pix_fg} !== {ev[2], ef[2]}) begin
            n_bad++;
            $display("FAIL %s pixel: got valid=%0b fg=%0b exp valid=%0b fg=%0b",
                     et[2], pix_valid, pix_fg, ev[2], ef[2]);
        end
        n_cmp++;
        if (ram_rd !== erd || (erd && ram_addr !== eaddr)) begin
            n_bad++;
            $display("FAIL %s read: got rd=%0b addr=%h exp rd=%0b addr=%h",
                     rtag, ram_rd, ram_addr, erd, eaddr);
        end
        ev[2] = ev[1]; ef[2] = ef[1]; et[2] = et[1];
        ev[1] = ev[0]; ef[1] = ef[0]; et[1] = et[0];
        frame_start = fs;
        pix_act     = act;
        ev[0] = 1'b0; ef[0] = 1'b0; et[0] = "R2"; erd = 1'b0; rtag = "R3";
        if (fs) begin
            bm_line = 0;
            bm_col  = 0;
        end else if (act) begin
            row = bm_line / (7 + 2);
            w   = bm_line % (7 + 2);
            blank = (bm_line < 0) || (row >= 7) || (w >= 7);
            ev[0] = 1'b1;
            if (bm_line < 0)      et[0] = "R1";
            else if (row >= 7)    et[0] = "R8";
            else if (w >= 7)      et[0] = "R7";
            else if (idle_mod > 0) et[0] = "R9/R4";
            else                  et[0] = "R2/R4";
            if (!blank) begin
                s = row * 7 + w;
                ef[0] = memf(16'(START + s * 16 + bm_col / 8))[7 - (bm_col % 8)];
                if (bm_col % 8 == 0) begin
                    erd   = 1'b1;
                    eaddr = 16'(START + s * 16 + bm_col / 8);
                    rtag  = (s == 0 && bm_col == 0) ? "R5" : (s > 0 ? "R6/R3" : "R3");
                end
            end
            if (bm_line >= 0) begin
                bm_col++;
                if (bm_col == 128) begin
                    bm_col = 0;
                    bm_line++;
                end
            end
        end
    endtask

    task automatic run_line(input int imod, input int tail);
        idle_mod = imod;
        for (int c = 0; c < 128; c++) begin
            if (imod > 0 && (c % imod) == 3) step(1'b0, 1'b0);
            step(1'b1, 1'b0);
        end
        for (int t = 0; t < tail; t++) step(1'b0, 1'b0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then pixels before any frame
        step(1'b0, 1'b0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
        // frame with idle cycles only at line ends, run past the end (R6, R7, R8)
        step(1'b0, 1'b1);
        for (int l = 0; l < 64; l++) run_line(0, 3);
        // frame with idle cycles inside byte groups, lines back to back (R9)
        step(1'b0, 1'b1);
        for (int l = 0; l < 62; l++) run_line(5, 0);
        // restart in mid-frame (R5)
        step(1'b0, 1'b1);
        for (int l = 0; l < 10; l++) run_line(0, 1);
        step(1'b0, 1'b1);
        for (int l = 0; l < 12; l++) run_line(7, 2);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        summary();
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: got hung run exp completion");
        summary();
        $finish;
    end
endmodule